// File: doc/BRIEF.md
# Dual-Channel Coherent Sample Freeze

This block sits between two acceleration channels (X and Y/Z) and the register file a serial host reads. It holds the most recent 14-bit two's-complement word of each channel. It presents each word as two 10-bit registers. The high register carries the upper ten bits. The low register carries the bottom four bits, right-justified. Because a full word takes two reads, and a coherent pair of channels takes more, the block can hold its registers still while a multi-read sequence is under way. A sample that arrives during such a hold is parked. It is released into the register once the sequence completes.

A 2-bit mode input picks the freeze policy:
- `00` (all bytes): any read holds both channels until all four registers have been read.
- `01` (per channel): a read holds only the channel it touched, until that channel's other register has been read.
- `10` (high pair): a high-register read holds both channels until the other channel's high register has been read. Low-register reads are ignored.
- `11` (live): the registers follow every sample.

A filter-reset input forces the read data to zero while it is high.

The policy controller is a four-state machine:
- `ST_LIVE`: nothing held.
- `ST_HOLD_X`: X held.
- `ST_HOLD_Y`: Y/Z held.
- `ST_HOLD_BOTH`: both held.

It also keeps a 4-bit read mask, with one bit per register. Bit 0 is X low, bit 1 is X high, bit 2 is Y low and bit 3 is Y high. The mode input selects which masks lead to which state:
- All-bytes mode and high-pair mode move `ST_LIVE` to `ST_HOLD_BOTH` and back.
- Per-channel mode moves between all four states.
- Live mode and any mode change return the machine to `ST_LIVE` with an empty mask.

Top module: `coherent_freeze_regs`

## Requirements
- R1: `rd_data` shows the register selected by `rd_chan` and `rd_high`. `rd_chan` 0 selects X and 1 selects Y/Z. `rd_high` 1 selects the high register. The high register is word bits [13:4]. The low register is six zeros above word bits [3:0]. `rd_data` is combinational, so a read strobe returns the value held in that same cycle.
- R2: In mode `11`, a sample presented with `smp_valid` in cycle t is visible in cycle t+1, even if a read is strobed in cycle t.
- R3: In mode `00`, a read strobe of any register holds both channels. They stay held until all four registers have been read. The register values stay stable while held.
- R4: In mode `01`, a read of one channel holds only that channel. That channel is released when its other register is read. The other channel keeps following samples.
- R5: In mode `10`, a high-register read holds both channels. They are released when the other channel's high register is read. Low-register reads change neither the hold nor the read mask.
- R6: Reading a register that was already read during the current hold does not count toward release.
- R7: On release, a held channel loads the latest sample that arrived during the hold, in the cycle after the completing read. If no sample arrived, it keeps its value and loads the next sample.
- R8: Any change of `mode` clears the hold state and the read mask. A sample parked during the hold is then loaded.
- R9: While `filt_rst` is 1, `rd_data` is zero for every selection.
- R10: After reset, both channel words are zero and nothing is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | New sample pair present this cycle |
| smp_x | input | 14 | X channel sample, two's complement |
| smp_y | input | 14 | Y/Z channel sample, two's complement |
| rd_en | input | 1 | Read strobe for the selected register |
| rd_chan | input | 1 | Channel select: 0 = X, 1 = Y/Z |
| rd_high | input | 1 | Register select: 1 = high, 0 = low |
| mode | input | 2 | Freeze policy: 00 all bytes, 01 per channel, 10 high pair, 11 live |
| filt_rst | input | 1 | Filter reset: forces read data to zero |
| rd_data | output | 10 | Selected register value |

## Verification
Several properties are checked on every cycle:
- A mode change empties the machine.
- Live mode never holds.
- A first read in all-bytes mode reaches `ST_HOLD_BOTH`, and in per-channel mode holds the channel that was read.
- Low reads in high-pair mode and repeated reads leave the mask untouched.
- A held word stays still.
- A released word takes the parked sample.

Other behaviours only the bench scenarios can show at the ports:
- Which read actually completes a sequence.
- That the latest of several parked samples wins.
- That a cleared mask turns a would-be completing read into a fresh hold.
- That the other channel keeps flowing in per-channel mode.
- The exact register formats.

// File: rtl/csf_pkg.sv
package csf_pkg;

    localparam int NCH = 2;

    localparam logic [1:0] MODE_ALL_BYTES = 2'b00;
    localparam logic [1:0] MODE_PER_CHAN  = 2'b01;
    localparam logic [1:0] MODE_HIGH_PAIR = 2'b10;
    localparam logic [1:0] MODE_LIVE      = 2'b11;

    // mask bit order: {Y high, Y low, X high, X low}
    localparam logic [3:0] HIGH_BITS = 4'b1010;

    typedef enum logic [1:0] {
        ST_LIVE      = 2'b00,
        ST_HOLD_X    = 2'b01,
        ST_HOLD_Y    = 2'b10,
        ST_HOLD_BOTH = 2'b11
    } frz_state_t;

    function automatic frz_state_t state_of(input logic fx, input logic fy);
        frz_state_t s;
        unique case ({fy, fx})
            2'b00:   s = ST_LIVE;
            2'b01:   s = ST_HOLD_X;
            2'b10:   s = ST_HOLD_Y;
            default: s = ST_HOLD_BOTH;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/csf_policy_fsm.sv
module csf_policy_fsm
    import csf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       rd_en,
    input  logic       rd_chan,
    input  logic       rd_high,
    output logic       hold_x,
    output logic       hold_y
);

    logic [1:0] mode_q;
    logic [3:0] mask_q;
    logic [3:0] mask_d;
    logic [3:0] rd_bit;
    logic [3:0] acc;
    logic       mode_chg;
    frz_state_t st_q;
    frz_state_t st_d;

    always_comb begin
        rd_bit   = rd_en ? (4'b0001 << {rd_chan, rd_high}) : 4'b0000;
        mode_chg = (mode != mode_q);
    end

    // next-state and mask policy
    always_comb begin
        mask_d = mask_q;
        st_d   = st_q;
        acc    = mask_q | rd_bit;
        unique case (mode)
            MODE_ALL_BYTES: begin
                if (acc == 4'hF) begin
                    mask_d = 4'h0;
                    st_d   = ST_LIVE;
                end else begin
                    mask_d = acc;
                    st_d   = (acc != 4'h0) ? ST_HOLD_BOTH : ST_LIVE;
                end
            end
            MODE_PER_CHAN: begin
                mask_d[1:0] = (acc[1:0] == 2'b11) ? 2'b00 : acc[1:0];
                mask_d[3:2] = (acc[3:2] == 2'b11) ? 2'b00 : acc[3:2];
                st_d        = state_of(|mask_d[1:0], |mask_d[3:2]);
            end
            MODE_HIGH_PAIR: begin
                acc = mask_q | (rd_bit & HIGH_BITS);
                if (acc[1] && acc[3]) begin
                    mask_d = 4'h0;
                    st_d   = ST_LIVE;
                end else begin
                    mask_d = acc;
                    st_d   = (acc != 4'h0) ? ST_HOLD_BOTH : ST_LIVE;
                end
            end
            default: begin
                mask_d = 4'h0;
                st_d   = ST_LIVE;
            end
        endcase
        if (mode_chg) begin
            mask_d = 4'h0;
            st_d   = ST_LIVE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_LIVE;
            mask_q <= 4'h0;
            mode_q <= MODE_ALL_BYTES;
        end else begin
            st_q   <= st_d;
            mask_q <= mask_d;
            mode_q <= mode;
        end
    end

    // outputs: hold decided from the state being entered
    always_comb begin
        hold_x = (st_d == ST_HOLD_X) || (st_d == ST_HOLD_BOTH);
        hold_y = (st_d == ST_HOLD_Y) || (st_d == ST_HOLD_BOTH);
    end

    p_live_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LIVE) |=> (st_q == ST_LIVE));

    p_any_byte_freezes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ALL_BYTES && !mode_chg && st_q == ST_LIVE && rd_en)
        |=> (st_q == ST_HOLD_BOTH));

    p_chan_isolate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PER_CHAN && !mode_chg && st_q == ST_LIVE && rd_en)
        |=> (st_q == ($past(rd_chan) ? ST_HOLD_Y : ST_HOLD_X)));

    p_low_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HIGH_PAIR && !mode_chg && !(rd_en && rd_high))
        |=> ($stable(mask_q) && $stable(st_q)));

    p_repeat_no_progress_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_chg && (mask_q & rd_bit) != 4'h0) |=> $stable(mask_q));

    p_mode_change_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (st_q == ST_LIVE && mask_q == 4'h0));

endmodule

// File: rtl/csf_chan_hold.sv
module csf_chan_hold #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         smp_valid,
    input  logic [W-1:0] smp,
    output logic [W-1:0] val
);

    logic [W-1:0] val_q;
    logic [W-1:0] pend_q;
    logic         pend_v_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q    <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else if (!hold) begin
            if (smp_valid) begin
                val_q <= smp;
            end else if (pend_v_q) begin
                val_q <= pend_q;
            end
            pend_v_q <= 1'b0;
        end else if (smp_valid) begin
            pend_q   <= smp;
            pend_v_q <= 1'b1;
        end
    end

    assign val = val_q;

    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(val_q));

    p_live_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && smp_valid) |=> (val_q == $past(smp)));

    p_release_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !smp_valid && pend_v_q) |=> (val_q == $past(pend_q)));

endmodule

// File: rtl/csf_reg_view.sv
module csf_reg_view #(
    parameter int DATA_W = 14,
    parameter int HI_W   = 10
) (
    input  logic [DATA_W-1:0] val_x,
    input  logic [DATA_W-1:0] val_y,
    input  logic              sel_chan,
    input  logic              sel_high,
    input  logic              zero,
    output logic [HI_W-1:0]   rd_data
);

    localparam int LO_W = DATA_W - HI_W;
    localparam int PAD  = HI_W - LO_W;

    logic [DATA_W-1:0] word;

    always_comb begin
        word = sel_chan ? val_y : val_x;
        if (zero) begin
            rd_data = '0;
        end else if (sel_high) begin
            rd_data = word[DATA_W-1:LO_W];
        end else begin
            rd_data = {{PAD{1'b0}}, word[LO_W-1:0]};
        end
    end

endmodule

// File: rtl/coherent_freeze_regs.sv
module coherent_freeze_regs
    import csf_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int HI_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_x,
    input  logic [DATA_W-1:0] smp_y,
    input  logic              rd_en,
    input  logic              rd_chan,
    input  logic              rd_high,
    input  logic [1:0]        mode,
    input  logic              filt_rst,
    output logic [HI_W-1:0]   rd_data
);

    logic [NCH-1:0]             hold_v;
    logic [NCH-1:0][DATA_W-1:0] smp_v;
    logic [NCH-1:0][DATA_W-1:0] val_v;

    assign smp_v[0] = smp_x;
    assign smp_v[1] = smp_y;

    csf_policy_fsm u_policy (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .rd_en   (rd_en),
        .rd_chan (rd_chan),
        .rd_high (rd_high),
        .hold_x  (hold_v[0]),
        .hold_y  (hold_v[1])
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        csf_chan_hold #(.W(DATA_W)) u_hold (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold      (hold_v[ch]),
            .smp_valid (smp_valid),
            .smp       (smp_v[ch]),
            .val       (val_v[ch])
        );
    end

    csf_reg_view #(.DATA_W(DATA_W), .HI_W(HI_W)) u_view (
        .val_x    (val_v[0]),
        .val_y    (val_v[1]),
        .sel_chan (rd_chan),
        .sel_high (rd_high),
        .zero     (filt_rst),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/coherent_freeze_regs_bench.sv
module coherent_freeze_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [13:0] smp_x = '0;
    logic [13:0] smp_y = '0;
    logic        rd_en = 1'b0;
    logic        rd_chan = 1'b0;
    logic        rd_high = 1'b0;
    logic [1:0]  mode = 2'b11;
    logic        filt_rst = 1'b0;
    logic [9:0]  rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    coherent_freeze_regs u_coherent_freeze_regs (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y),
        .rd_en(rd_en), .rd_chan(rd_chan), .rd_high(rd_high), .mode(mode),
        .filt_rst(filt_rst), .rd_data(rd_data)
    );

    // one cycle of stimulus, optionally pushing an expected read value
    task automatic step(input logic sv, input logic [13:0] sx, input logic [13:0] sy,
                        input logic re, input logic ch, input logic hi,
                        input logic chk, input logic [9:0] ev, input string tag);
        @(negedge clk);
        smp_valid = sv; smp_x = sx; smp_y = sy;
        rd_en = re; rd_chan = ch; rd_high = hi;
        if (chk) begin
            exp_q.push_back(ev);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle();
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "");
    endtask

    task automatic sample(input logic [13:0] sx, input logic [13:0] sy);
        step(1'b1, sx, sy, 1'b0, 1'b0, 1'b0, 1'b0, '0, "");
    endtask

    task automatic rd(input logic ch, input logic hi, input logic [9:0] ev, input string tag);
        step(1'b0, '0, '0, 1'b1, ch, hi, 1'b1, ev, tag);
    endtask

    task automatic peek(input logic ch, input logic hi, input logic [9:0] ev, input string tag);
        step(1'b0, '0, '0, 1'b0, ch, hi, 1'b1, ev, tag);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        smp_valid = 1'b0; rd_en = 1'b0; mode = m;
    endtask

    task automatic set_filt(input logic v);
        @(negedge clk);
        smp_valid = 1'b0; rd_en = 1'b0; filt_rst = v;
    endtask

    // monitor: compare each expected item in the cycle it was driven
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                logic [9:0] ev;
                string      tg;
                ev = exp_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if (rd_data !== ev) begin
                    errors++;
                    $display("FAIL %s: rd_data=%h expected=%h", tg, rd_data, ev);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R10 reset state
        peek(1'b0, 1'b1, 10'h000, "R10 X high after reset");
        peek(1'b1, 1'b0, 10'h000, "R10 Y low after reset");

        // R1 / R2 live mode and formats
        sample(14'h3CE0, 14'h0320);
        peek(1'b0, 1'b1, 10'h3CE, "R1 X high of -800");
        peek(1'b0, 1'b0, 10'h000, "R1 X low of -800");
        peek(1'b1, 1'b1, 10'h032, "R1 Y high of 800");
        sample(14'h3FFF, 14'h1234);
        peek(1'b0, 1'b0, 10'h00F, "R1 X low of -1");
        peek(1'b1, 1'b1, 10'h123, "R1 Y high");
        peek(1'b1, 1'b0, 10'h004, "R1 Y low");
        step(1'b1, 14'h0AB5, 14'h0111, 1'b1, 1'b0, 1'b1, 1'b1, 10'h3FF, "R2 read with sample");
        peek(1'b0, 1'b1, 10'h0AB, "R2 live update after read");

        // R3 mode 00
        set_mode(2'b00);
        sample(14'h1111, 14'h2222);
        rd(1'b0, 1'b1, 10'h111, "R3 first read");
        sample(14'h0333, 14'h0444);
        peek(1'b0, 1'b1, 10'h111, "R3 X held");
        peek(1'b1, 1'b1, 10'h222, "R3 Y held");
        rd(1'b0, 1'b0, 10'h001, "R3 X low");
        rd(1'b1, 1'b1, 10'h222, "R3 Y high");
        rd(1'b1, 1'b1, 10'h222, "R6 repeat Y high");
        peek(1'b0, 1'b1, 10'h111, "R6 still held after repeat");
        sample(14'h0555, 14'h0666);
        rd(1'b1, 1'b0, 10'h002, "R3 completing read");
        peek(1'b0, 1'b1, 10'h055, "R7 latest parked X");
        peek(1'b1, 1'b0, 10'h006, "R7 latest parked Y");
        rd(1'b0, 1'b1, 10'h055, "R3 round two");
        rd(1'b0, 1'b0, 10'h005, "R3 round two");
        rd(1'b1, 1'b1, 10'h066, "R3 round two");
        rd(1'b1, 1'b0, 10'h006, "R3 round two");
        peek(1'b0, 1'b1, 10'h055, "R7 no parked sample keeps value");
        sample(14'h0777, 14'h0888);
        peek(1'b0, 1'b1, 10'h077, "R7 next sample loads");

        // R4 mode 01
        set_mode(2'b01);
        rd(1'b0, 1'b0, 10'h007, "R4 X low read");
        sample(14'h0999, 14'h0AAA);
        peek(1'b0, 1'b1, 10'h077, "R4 X held");
        peek(1'b1, 1'b1, 10'h0AA, "R4 Y follows");
        rd(1'b0, 1'b1, 10'h077, "R4 X other byte");
        peek(1'b0, 1'b1, 10'h099, "R4 X released to parked");
        rd(1'b1, 1'b1, 10'h0AA, "R4 Y high read");
        rd(1'b1, 1'b1, 10'h0AA, "R6 repeat Y high per chan");
        sample(14'h0121, 14'h0343);
        peek(1'b1, 1'b0, 10'h00A, "R4 Y held");
        peek(1'b0, 1'b1, 10'h012, "R4 X follows");
        rd(1'b1, 1'b0, 10'h00A, "R4 Y other byte");
        peek(1'b1, 1'b1, 10'h034, "R4 Y released");

        // R5 mode 10
        set_mode(2'b10);
        rd(1'b0, 1'b0, 10'h001, "R5 low read ignored");
        sample(14'h0BBB, 14'h0CCC);
        peek(1'b0, 1'b1, 10'h0BB, "R5 no hold from low read");
        rd(1'b0, 1'b1, 10'h0BB, "R5 X high holds");
        sample(14'h0DDD, 14'h0EEE);
        rd(1'b1, 1'b0, 10'h00C, "R5 Y low ignored while held");
        rd(1'b0, 1'b1, 10'h0BB, "R6 repeat X high");
        peek(1'b1, 1'b1, 10'h0CC, "R5 Y held");
        rd(1'b1, 1'b1, 10'h0CC, "R5 Y high releases");
        peek(1'b0, 1'b1, 10'h0DD, "R5 X released");
        peek(1'b1, 1'b1, 10'h0EE, "R5 Y released");

        // R8 mode change
        set_mode(2'b00);
        rd(1'b0, 1'b1, 10'h0DD, "R8 hold in mode 00");
        sample(14'h0123, 14'h0456);
        peek(1'b0, 1'b1, 10'h0DD, "R8 held before change");
        set_mode(2'b11);
        peek(1'b0, 1'b1, 10'h012, "R8 change loads parked");
        set_mode(2'b00);
        rd(1'b0, 1'b1, 10'h012, "R8 partial");
        rd(1'b0, 1'b0, 10'h003, "R8 partial");
        rd(1'b1, 1'b1, 10'h045, "R8 partial");
        set_mode(2'b01);
        set_mode(2'b00);
        rd(1'b1, 1'b0, 10'h006, "R8 fresh hold");
        sample(14'h0789, 14'h0ABC);
        peek(1'b1, 1'b1, 10'h045, "R8 mask cleared so still held");

        // R9 filter reset
        set_filt(1'b1);
        peek(1'b0, 1'b1, 10'h000, "R9 X high zero");
        peek(1'b1, 1'b0, 10'h000, "R9 Y low zero");
        set_filt(1'b0);
        peek(1'b1, 1'b1, 10'h045, "R9 value back");

        idle();
        idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule